// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that completes every instruction in one clock. It runs a compact load/store instruction subset:

- register-register arithmetic and logic: add, subtract, bitwise and, bitwise or, and signed set-on-less-than
- word load and word store
- branch when two registers are equal
- unconditional jump

Instructions and data sit in two separate internal word arrays. The instruction array is filled from the testbench before reset is released, by writing the array directly.

The control path decodes in two levels. The main decoder looks at the opcode and produces a set of strobes plus a 2-bit operation class. A second decoder combines that class with the function field to choose one of five 3-bit ALU operations. The next PC is chosen in priority order:

1. the jump target, if the instruction is a jump;
2. otherwise the branch target, if the instruction is a taken branch;
3. otherwise PC+4.

The jump target keeps the top four bits of PC+4 and fills the rest with the 26-bit index shifted left by two.

Debug outputs show the PC and the register-file and data-memory write activity of the instruction being executed.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset drives the PC to 0 and clears every register, so a register read after reset returns 0 even if it held a value before.
- R2: The PC changes on every clock with no enable. An instruction that is neither a jump nor a taken branch moves it to PC+4.
- R3: Opcode 000000 writes register rd (bits 15..11) with rs (bits 25..21) op rt (bits 20..16). The function field (bits 5..0) selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-on-less-than (result 1 or 0).
- R4: Opcode 100011 writes register rt with data word ((rs + sign-extended bits 15..0) >> 2).
- R5: Opcode 101011 writes rt to data word ((rs + sign-extended imm) >> 2) and makes no register write.
- R6: Opcode 000100 makes no write. When rs equals rt the next PC is PC+4 + (sign-extended imm << 2), otherwise it is PC+4.
- R7: Opcode 000010 makes no write and loads the PC with {PC+4[31:28], bits 25..0, 2'b00}.
- R8: Register 0 always reads as 0, and writes aimed at it have no effect.
- R9: Any other opcode writes neither registers nor memory and advances the PC by 4.
- R10: A loop built from these instructions that sums the squares of 0 through 10 stores 385.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pcOut | output | 32 | Address of the instruction being executed |
| rfWrEn | output | 1 | Current instruction writes the register file |
| rfWrAddr | output | 5 | Destination register number |
| rfWrData | output | 32 | Value written to the register file |
| dmWrEn | output | 1 | Current instruction writes data memory |
| dmWrAddr | output | 32 | Byte address of the data-memory write |
| dmWrData | output | 32 | Word written to data memory |

## Verification
A bench-side instruction model runs alongside the core and compares every cycle's PC and write activity.

- The program branches backwards with a negative offset and leaves loops through both the taken and the not-taken branch path. A core with a wrong offset shift or wrong sign extension would land on the wrong PC at once.
- A subtract produces -1, which then feeds a set-on-less-than. An unsigned compare would write 0 instead of 1.
- A write aimed at register 0 is followed by a store of register 0. A core that honours that write would store 2 instead of 0.
- The program is run a second time after a fresh reset. A register file that is not cleared would leak the earlier sum of 385 into the first store.
- An undefined opcode with non-zero fields must leave both write enables low.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluCtl;
  } ctrl_t;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] opcode;
  logic [5:0] funct;
  logic [1:0] opClass;
  logic       unusedFields;

  assign opcode       = instr[31:26];
  assign funct        = instr[5:0];
  assign unusedFields = ^instr[25:6];

  always_comb begin
    ctrl    = '0;
    opClass = 2'b00;
    // first level: opcode -> strobes and operation class
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
        opClass       = 2'b10;
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        opClass     = 2'b01;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
    // second level: class and function field -> ALU operation
    case (opClass)
      2'b01:   ctrl.aluCtl = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  ctrl.aluCtl = ALU_SUB;
          FN_AND:  ctrl.aluCtl = ALU_AND;
          FN_OR:   ctrl.aluCtl = ALU_OR;
          FN_SLT:  ctrl.aluCtl = ALU_SLT;
          default: ctrl.aluCtl = ALU_ADD;
        endcase
      end
      default: ctrl.aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluOp_e           op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y,
  output logic             zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NUM_REGS   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrl_t       ctrl,
  output logic [31:0] instr,
  output logic        aluZero,
  output logic [31:0] pcOut,
  output logic [4:0]  wrAddr,
  output logic [31:0] wbData,
  output logic [31:0] aluRes,
  output logic [31:0] storeData
);
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [31:0] instrMem [IMEM_WORDS];
  logic [31:0] dataMem  [DMEM_WORDS];
  logic [31:0] regs     [NUM_REGS];

  logic [31:0] pc, pcPlus4, pcNext, immExt, branchTgt, jumpTgt;
  logic [31:0] rdA, rdB, aluB, memRd;
  logic [4:0]  rsIdx, rtIdx, rdIdx;

  // instruction array starts as all-zero words; the bench fills it
  initial begin
    for (int k = 0; k < IMEM_WORDS; k++) instrMem[k] = '0;
  end

  assign instr   = instrMem[pc[IA_W+1:2]];
  assign rsIdx   = instr[25:21];
  assign rtIdx   = instr[20:16];
  assign rdIdx   = instr[15:11];
  assign immExt  = {{16{instr[15]}}, instr[15:0]};
  assign pcPlus4 = pc + 32'd4;

  assign rdA = (rsIdx == '0) ? '0 : regs[rsIdx];
  assign rdB = (rtIdx == '0) ? '0 : regs[rtIdx];

  assign aluB = ctrl.aluSrc ? immExt : rdB;

  sc_alu #(.WIDTH(32)) u_alu (
    .op  (ctrl.aluCtl),
    .a   (rdA),
    .b   (aluB),
    .y   (aluRes),
    .zero(aluZero)
  );

  assign memRd  = ctrl.memRead ? dataMem[aluRes[DA_W+1:2]] : '0;
  assign wbData = ctrl.memToReg ? memRd : aluRes;
  assign wrAddr = ctrl.regDst ? rdIdx : rtIdx;

  assign branchTgt = pcPlus4 + {immExt[29:0], 2'b00};
  assign jumpTgt   = {pcPlus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   pcNext = jumpTgt;
    else if (ctrl.branch && aluZero) pcNext = branchTgt;
    else                             pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
    end else if (ctrl.regWrite && wrAddr != '0) begin
      regs[wrAddr] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && ctrl.memWrite) dataMem[aluRes[DA_W+1:2]] <= rdB;
  end

  assign pcOut     = pc;
  assign storeData = rdB;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  output logic        rfWrEn,
  output logic [4:0]  rfWrAddr,
  output logic [31:0] rfWrData,
  output logic        dmWrEn,
  output logic [31:0] dmWrAddr,
  output logic [31:0] dmWrData
);
  ctrl_t       ctrl;
  logic [31:0] instr;
  logic        aluZero;

  sc_control u_ctl (
    .instr(instr),
    .ctrl (ctrl)
  );

  sc_datapath #(
    .IMEM_WORDS(IMEM_WORDS),
    .DMEM_WORDS(DMEM_WORDS),
    .NUM_REGS  (32)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .instr    (instr),
    .aluZero  (aluZero),
    .pcOut    (pcOut),
    .wrAddr   (rfWrAddr),
    .wbData   (rfWrData),
    .aluRes   (dmWrAddr),
    .storeData(dmWrData)
  );

  assign rfWrEn = ctrl.regWrite;
  assign dmWrEn = ctrl.memWrite;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input ctrl_t       ctrl,
  input logic        aluZero,
  input logic        rfWrEn,
  input logic        dmWrEn
);
  // R1: reset forces the PC to zero
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pcOut == 32'd0);

  // R2: no jump and no branch means PC+4
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.branch) |=> pcOut == $past(pcOut) + 32'd4);

  // R5: a store never writes the register file
  p_store_excl_r5: assert property (@(posedge clk) disable iff (rst)
    dmWrEn |-> !rfWrEn);

  // R6: a taken branch lands on PC+4 plus the scaled offset
  p_beq_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && aluZero) |=>
      pcOut == $past(pcOut) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R6: a branch that is not taken falls through
  p_beq_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && !aluZero) |=> pcOut == $past(pcOut) + 32'd4);

  // R7: the low 28 bits of a jump come from the index field
  p_jump_low_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> pcOut[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

bind sc_core sc_core_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pcOut  (pcOut),
  .instr  (instr),
  .ctrl   (ctrl),
  .aluZero(aluZero),
  .rfWrEn (rfWrEn),
  .dmWrEn (dmWrEn)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_LEN   = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, rfWrData, dmWrAddr, dmWrData;
  logic [4:0]  rfWrAddr;
  logic        rfWrEn, dmWrEn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [31:0] prog  [PROG_LEN];
  logic [31:0] mReg  [32];
  logic [31:0] mMem  [64];
  logic [31:0] mPc;
  int          sumSq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .pcOut(pcOut),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .dmWrEn(dmWrEn), .dmWrAddr(dmWrAddr), .dmWrData(dmWrData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int wordIdx);
    return {6'b000010, 26'(wordIdx)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s pc=%h actual=%h expected=%h", tag, mPc, act, exp);
    end
  endtask

  // bench-side instruction model: compare this cycle, then advance
  task automatic stepModel();
    logic [31:0] w, se, a, b, res, addr, nextPc;
    logic [5:0]  op, fn;
    bit          eRf, eDm;
    logic [4:0]  eAddr;
    string       tag;
    w = prog[mPc[6:2]];
    op = w[31:26]; fn = w[5:0];
    se = {{16{w[15]}}, w[15:0]};
    a = (w[25:21] == 0) ? 32'd0 : mReg[w[25:21]];
    b = (w[20:16] == 0) ? 32'd0 : mReg[w[20:16]];
    eRf = 0; eDm = 0; eAddr = '0; res = '0; addr = '0;
    nextPc = mPc + 4;
    case (op)
      6'b000000: begin
        tag = "R3"; eRf = 1; eAddr = w[15:11];
        case (fn)
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   res = a + b;
        endcase
      end
      6'b100011: begin
        tag = "R4"; eRf = 1; eAddr = w[20:16];
        addr = a + se; res = mMem[addr[7:2]];
      end
      6'b101011: begin
        tag = "R5"; eDm = 1; addr = a + se;
      end
      6'b000100: begin
        tag = "R6";
        if (a == b) nextPc = mPc + 4 + (se << 2);
      end
      6'b000010: begin
        tag = "R7";
        nextPc = {nextPc[31:28], w[25:0], 2'b00};
      end
      default: tag = "R9";
    endcase
    chk("R2", pcOut, mPc);
    chk(tag, {31'd0, rfWrEn}, {31'd0, eRf});
    chk(tag, {31'd0, dmWrEn}, {31'd0, eDm});
    if (eRf) begin
      chk(tag, {27'd0, rfWrAddr}, {27'd0, eAddr});
      chk(tag, rfWrData, res);
    end
    if (eDm) begin
      chk(tag, dmWrAddr, addr);
      chk(tag, dmWrData, b);
    end
    if (mPc == 32'd88) chk("R8", dmWrData, 32'd0);
    if (mPc == 32'd92) chk("R10", rfWrData, 32'(sumSq));
    if (eRf && eAddr != 0) mReg[eAddr] = res;
    if (eDm) mMem[addr[7:2]] = b;
    mPc = nextPc;
  endtask

  task automatic resetModel();
    for (int k = 0; k < 32; k++) mReg[k] = '0;
    mPc = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    sumSq = 0;
    for (int k = 0; k <= 10; k++) sumSq += k * k;

    prog[0]  = encI(6'b101011, 0, 2, 16);   // store r2 (must be 0 after reset)
    prog[1]  = encI(6'b100011, 0, 6, 0);    // r6 = 1
    prog[2]  = encI(6'b100011, 0, 3, 4);    // r3 = 11
    prog[3]  = encR(0, 0, 1, 6'b100000);
    prog[4]  = encR(0, 0, 2, 6'b100000);
    prog[5]  = encI(6'b000100, 1, 3, 10);   // outer exit -> 16
    prog[6]  = encR(0, 0, 5, 6'b100000);
    prog[7]  = encR(0, 0, 4, 6'b100000);
    prog[8]  = encI(6'b000100, 4, 1, 3);    // inner exit -> 12
    prog[9]  = encR(5, 1, 5, 6'b100000);
    prog[10] = encR(4, 6, 4, 6'b100000);
    prog[11] = encJ(8);
    prog[12] = encR(2, 5, 2, 6'b100000);
    prog[13] = encI(6'b101011, 0, 2, 8);
    prog[14] = encR(1, 6, 1, 6'b100000);
    prog[15] = encJ(5);
    prog[16] = encR(2, 3, 7, 6'b101010);    // 385 < 11 -> 0
    prog[17] = encR(0, 6, 8, 6'b100010);    // -1
    prog[18] = encR(8, 0, 9, 6'b101010);    // signed -1 < 0 -> 1
    prog[19] = encR(2, 3, 10, 6'b100100);
    prog[20] = encR(2, 3, 11, 6'b100101);
    prog[21] = encR(6, 6, 0, 6'b100000);    // write aimed at r0
    prog[22] = encI(6'b101011, 0, 0, 12);   // store r0
    prog[23] = encI(6'b100011, 0, 12, 8);   // read back the sum
    prog[24] = {6'b111111, 5'd6, 5'd7, 16'h1234};  // undefined opcode
    prog[25] = encI(6'b000100, 0, 0, -1);   // spin

    for (int k = 0; k < 64; k++) mMem[k] = '0;
    mMem[0] = 32'd1;
    mMem[1] = 32'd11;

    #1;
    for (int k = 0; k < PROG_LEN; k++) i_sc_core.u_dp.instrMem[k] = prog[k];
    i_sc_core.u_dp.dataMem[0] = 32'd1;
    i_sc_core.u_dp.dataMem[1] = 32'd11;

    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", pcOut, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < 500; c++) begin
      stepModel();
      @(negedge clk);
    end

    // second reset: registers that held results must read zero again
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", pcOut, 32'd0);
    resetModel();
    rst = 1'b0;
    chk("R1", dmWrData, 32'd0);
    for (int c = 0; c < 10; c++) begin
      stepModel();
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule